// File: doc/BRIEF.md
# Double-Precision to 32-bit Integer Converter

This block turns a 64-bit IEEE-754 binary floating-point operand into a signed 32-bit integer. A 2-bit rounding-mode field is held inside the block and selects how the fractional part is removed. The field is written through a dedicated write strobe, and a write replaces its old value. One shared datapath serves all four modes. It unpacks the operand, aligns the significand into a fixed-point integer/fraction split, decides whether to increment, checks the range and substitutes a fixed invalid pattern when needed.

The converted value and the exception flags are registered and appear one clock after the operand is presented. The invalid, overflow and inexact flags are sticky status bits. Each conversion ORs its own flags into them, and only reset clears them. The surrounding core reads these flags and the current rounding mode directly from the output ports.

Top module: `f64_to_i32_cvt`

## Requirements
- R1: The mode field encodes 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity. A write stores the 2-bit value in place of the old one, and the field holds when no write is made.
- R2: In mode 0 the result is the integer nearest the operand. An operand exactly halfway between two integers goes to the even one.
- R3: In mode 1 the fraction is discarded, so the result moves toward zero.
- R4: In mode 2 the result is the ceiling of the operand.
- R5: In mode 3 the result is the floor of the operand.
- R6: A NaN or infinite operand (exponent field all ones) sets both the invalid flag and the overflow flag and yields 0x7FFFFFFF.
- R7: A rounded value above 2147483647 or below -2147483648 sets both the invalid flag and the overflow flag and yields 0x7FFFFFFF. Exactly -2147483648 is a valid result.
- R8: The inexact flag is set when a valid result differs from the operand. An invalid conversion does not set it.
- R9: Flags are sticky. A later conversion never clears a flag, and only reset returns the flags to 0.
- R10: The result and a one-cycle result-valid pulse appear in the cycle after op_valid. The result holds until the next conversion.
- R11: After reset, res_valid is 0, the result is 0, all flags are 0 and the mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the rounding-mode field |
| mode_wdata | input | 2 | New rounding-mode value |
| op_valid | input | 1 | Operand present this cycle |
| op_bits | input | 64 | IEEE-754 double operand |
| rmode | output | 2 | Current rounding mode |
| res_valid | output | 1 | Result registered from the previous cycle's operand |
| res_int | output | 32 | Signed integer result |
| flg_invalid | output | 1 | Sticky invalid flag |
| flg_overflow | output | 1 | Sticky overflow flag |
| flg_inexact | output | 1 | Sticky inexact flag |

## Verification
Every conversion result and its flag update is due one clock edge after op_valid is sampled, and a mode write takes effect one edge after the strobe. The bench drives inputs on the falling edge and samples on the next falling edge, which is half a period after the edge that loads the registers. Before each sweep point the bench resets the block and rewrites the mode, so every flag seen belongs to that one operand. A separate sequence chains conversions to show that the flags accumulate and that the result holds between conversions.

// File: rtl/f64cvt_pkg.sv
package f64cvt_pkg;
  localparam int FP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int BIAS   = 1023;
  localparam int UEXP_W = EXP_W + 2;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_UP        = 2'd2,
    RM_DOWN      = 2'd3
  } rmode_e;
endpackage

// File: rtl/cvt_unpack.sv
module cvt_unpack
  import f64cvt_pkg::*;
(
  input  logic [FP_W-1:0]          op,
  output logic                     sign,
  output logic signed [UEXP_W-1:0] uexp,
  output logic [FRAC_W:0]          sig,
  output logic                     nonfinite
);
  logic [EXP_W-1:0] bexp;

  always_comb begin
    sign      = op[FP_W-1];
    bexp      = op[FP_W-2 -: EXP_W];
    // Hidden bit is present only for normal numbers.
    sig       = {(bexp != '0), op[FRAC_W-1:0]};
    // Subnormals land far below -1 and are treated as tiny.
    uexp      = $signed({2'b00, bexp}) - $signed(UEXP_W'(BIAS));
    nonfinite = (bexp == '1);
  end
endmodule

// File: rtl/cvt_align.sv
module cvt_align
  import f64cvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic signed [UEXP_W-1:0] uexp,
  input  logic [FRAC_W:0]          sig,
  output logic [INT_W-1:0]         ipart,
  output logic                     guard,
  output logic                     sticky,
  output logic                     huge
);
  localparam int FIX_W = INT_W + FRAC_W + 1;
  localparam int SH_W  = $clog2(INT_W + 1);

  logic [FIX_W-1:0]  fixv;
  logic [SH_W-1:0]   sh;
  logic              tiny;
  logic [UEXP_W-1:0] sh_full;

  always_comb begin
    huge    = (uexp >= $signed(UEXP_W'(INT_W)));
    tiny    = (uexp < $signed(-(UEXP_W'(1))));
    sh_full = UEXP_W'(uexp + $signed(UEXP_W'(1)));
    sh      = sh_full[SH_W-1:0];
    // Fixed point: INT_W integer bits above FRAC_W+1 fraction bits.
    fixv    = {{INT_W{1'b0}}, sig} << sh;
    if (tiny || huge) begin
      ipart  = '0;
      guard  = 1'b0;
      sticky = |sig;
    end else begin
      ipart  = fixv[FIX_W-1 -: INT_W];
      guard  = fixv[FRAC_W];
      sticky = |fixv[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import f64cvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [1:0]       mode,
  input  logic             sign,
  input  logic [INT_W-1:0] ipart,
  input  logic             guard,
  input  logic             sticky,
  input  logic             huge,
  input  logic             nonfinite,
  output logic [INT_W-1:0] result,
  output logic             f_inv,
  output logic             f_ovf,
  output logic             f_inx
);
  localparam logic [INT_W:0]   POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0]   NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] BAD_VAL = {1'b0, {(INT_W-1){1'b1}}};

  logic           inc;
  logic [INT_W:0] mag;
  logic           oor;
  logic           frac;

  always_comb begin
    frac = guard | sticky;
    unique case (rmode_e'(mode))
      RM_NEAR_EVEN: inc = guard & (sticky | ipart[0]);
      RM_TO_ZERO:   inc = 1'b0;
      RM_UP:        inc = ~sign & frac;
      RM_DOWN:      inc = sign & frac;
      default:      inc = 1'b0;
    endcase
    mag    = {1'b0, ipart} + {{INT_W{1'b0}}, inc};
    oor    = huge | (sign ? (mag > NEG_LIM) : (mag > POS_LIM));
    f_inv  = nonfinite | oor;
    f_ovf  = f_inv;
    f_inx  = ~f_inv & frac;
    if (f_inv)     result = BAD_VAL;
    else if (sign) result = ~mag[INT_W-1:0] + 1'b1;
    else           result = mag[INT_W-1:0];
  end
endmodule

// File: rtl/f64_to_i32_cvt.sv
module f64_to_i32_cvt
  import f64cvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic             op_valid,
  input  logic [63:0]      op_bits,
  output logic [1:0]       rmode,
  output logic             res_valid,
  output logic [INT_W-1:0] res_int,
  output logic             flg_invalid,
  output logic             flg_overflow,
  output logic             flg_inexact
);
  localparam logic [INT_W-1:0] BAD_VAL = {1'b0, {(INT_W-1){1'b1}}};

  logic                     u_sign, u_nonfin;
  logic signed [UEXP_W-1:0] u_exp;
  logic [FRAC_W:0]          u_sig;
  logic [INT_W-1:0]         a_int;
  logic                     a_guard, a_sticky, a_huge;
  logic [INT_W-1:0]         r_val;
  logic                     r_inv, r_ovf, r_inx;

  cvt_unpack u_unpack (
    .op(op_bits), .sign(u_sign), .uexp(u_exp), .sig(u_sig), .nonfinite(u_nonfin)
  );

  cvt_align #(.INT_W(INT_W)) u_align (
    .uexp(u_exp), .sig(u_sig), .ipart(a_int), .guard(a_guard),
    .sticky(a_sticky), .huge(a_huge)
  );

  cvt_round #(.INT_W(INT_W)) u_round (
    .mode(rmode), .sign(u_sign), .ipart(a_int), .guard(a_guard),
    .sticky(a_sticky), .huge(a_huge), .nonfinite(u_nonfin),
    .result(r_val), .f_inv(r_inv), .f_ovf(r_ovf), .f_inx(r_inx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rmode        <= 2'd0;
      res_valid    <= 1'b0;
      res_int      <= '0;
      flg_invalid  <= 1'b0;
      flg_overflow <= 1'b0;
      flg_inexact  <= 1'b0;
    end else begin
      if (mode_wr) rmode <= mode_wdata;
      res_valid <= op_valid;
      if (op_valid) begin
        res_int      <= r_val;
        flg_invalid  <= flg_invalid  | r_inv;
        flg_overflow <= flg_overflow | r_ovf;
        flg_inexact  <= flg_inexact  | r_inx;
      end
    end
  end

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |=> $stable(rmode));
  p_nonfinite_flags_r6: assert property (@(posedge clk) disable iff (rst)
    op_valid && u_nonfin |=> flg_invalid && flg_overflow && res_int == BAD_VAL);
  p_huge_flags_r7: assert property (@(posedge clk) disable iff (rst)
    op_valid && a_huge |=> flg_invalid && flg_overflow && res_int == BAD_VAL);
  p_sticky_inv_r9: assert property (@(posedge clk) disable iff (rst)
    flg_invalid |=> flg_invalid);
  p_sticky_inx_r9: assert property (@(posedge clk) disable iff (rst)
    flg_inexact |=> flg_inexact);
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(res_int));
endmodule

// File: tb/f64_to_i32_cvt_tb_top.sv
module f64_to_i32_cvt_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_wdata = 2'd0;
  logic        op_valid = 1'b0;
  logic [63:0] op_bits = 64'd0;
  logic [1:0]  rmode;
  logic        res_valid;
  logic [31:0] res_int;
  logic        flg_invalid, flg_overflow, flg_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  f64_to_i32_cvt dut_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .op_valid(op_valid), .op_bits(op_bits), .rmode(rmode),
    .res_valid(res_valid), .res_int(res_int), .flg_invalid(flg_invalid),
    .flg_overflow(flg_overflow), .flg_inexact(flg_inexact)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr_mode(input logic [1:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic apply(input logic [63:0] b);
    @(negedge clk); op_valid = 1'b1; op_bits = b;
    @(negedge clk); op_valid = 1'b0;
  endtask

  // Reference model built from the rounding definitions.
  task automatic model(input logic [63:0] b, input logic [1:0] m,
                       output logic [31:0] r, output logic inv, output logic inx);
    real x, fl, d, rv;
    if (b[62:52] == 11'h7FF) begin
      r = 32'h7FFFFFFF; inv = 1'b1; inx = 1'b0;
    end else begin
      x  = $bitstoreal(b);
      fl = $floor(x);
      case (m)
        2'd0: begin
          d = x - fl;
          if (d > 0.5) rv = fl + 1.0;
          else if (d < 0.5) rv = fl;
          else rv = ($floor(fl / 2.0) == fl / 2.0) ? fl : fl + 1.0;
        end
        2'd1: rv = (x >= 0.0) ? fl : $ceil(x);
        2'd2: rv = $ceil(x);
        default: rv = fl;
      endcase
      if (rv > 2147483647.0 || rv < -2147483648.0) begin
        r = 32'h7FFFFFFF; inv = 1'b1; inx = 1'b0;
      end else begin
        r = 32'($rtoi(rv)); inv = 1'b0; inx = (rv != x);
      end
    end
  endtask

  task automatic sweep_one(input logic [1:0] m, input logic [63:0] b, input string req);
    logic [31:0] er;
    logic ei, ex;
    model(b, m, er, ei, ex);
    do_reset();
    wr_mode(m);
    apply(b);
    chk({req, " result"}, res_int, er);
    chk("R6/R7 invalid", {31'd0, flg_invalid}, {31'd0, ei});
    chk("R6/R7 overflow", {31'd0, flg_overflow}, {31'd0, ei});
    chk("R8 inexact", {31'd0, flg_inexact}, {31'd0, ex});
    chk("R10 valid pulse", {31'd0, res_valid}, 32'd1);
  endtask

  initial begin
    logic [63:0] specials [0:17];
    string rq;
    specials[0]  = $realtobits(2147483647.0);
    specials[1]  = $realtobits(2147483647.4);
    specials[2]  = $realtobits(2147483647.5);
    specials[3]  = $realtobits(-2147483648.0);
    specials[4]  = $realtobits(-2147483648.4);
    specials[5]  = $realtobits(-2147483648.5);
    specials[6]  = $realtobits(2147483648.0);
    specials[7]  = $realtobits(1.0e20);
    specials[8]  = $realtobits(-1.0e20);
    specials[9]  = 64'h0000000000000001;
    specials[10] = 64'h8000000000000001;
    specials[11] = 64'h7FF8000000000000;
    specials[12] = 64'h7FF0000000000000;
    specials[13] = 64'hFFF0000000000000;
    specials[14] = 64'h8000000000000000;
    specials[15] = $realtobits(0.49999999);
    specials[16] = $realtobits(-1234567.75);
    specials[17] = $realtobits(2147483646.5);

    do_reset();
    @(negedge clk);
    chk("R11 valid", {31'd0, res_valid}, 32'd0);
    chk("R11 result", res_int, 32'd0);
    chk("R11 flags", {29'd0, flg_invalid, flg_overflow, flg_inexact}, 32'd0);
    chk("R11 mode", {30'd0, rmode}, 32'd0);

    // R1: write replaces, and holds without a strobe
    wr_mode(2'd2);
    chk("R1 write", {30'd0, rmode}, 32'd2);
    wr_mode(2'd1);
    chk("R1 replace", {30'd0, rmode}, 32'd1);
    @(negedge clk); @(negedge clk);
    chk("R1 hold", {30'd0, rmode}, 32'd1);

    for (int m = 0; m < 4; m++) begin
      case (m)
        0: rq = "R2";
        1: rq = "R3";
        2: rq = "R4";
        default: rq = "R5";
      endcase
      for (int k = -40; k <= 40; k++)
        sweep_one(2'(m), $realtobits(real'(k) / 4.0), rq);
      for (int s = 0; s < 18; s++)
        sweep_one(2'(m), specials[s], "R6/R7");
    end

    // R9 stickiness and R10 hold across chained conversions
    do_reset();
    apply(64'h7FF8000000000000);
    apply($realtobits(1.0));
    chk("R9 result after nan", res_int, 32'd1);
    chk("R9 invalid kept", {31'd0, flg_invalid}, 32'd1);
    chk("R9 overflow kept", {31'd0, flg_overflow}, 32'd1);
    chk("R8 exact no inexact", {31'd0, flg_inexact}, 32'd0);
    apply($realtobits(2.5));
    chk("R2 tie even", res_int, 32'd2);
    apply($realtobits(-7.0));
    chk("R9 inexact kept", {31'd0, flg_inexact}, 32'd1);
    chk("R10 result", res_int, 32'hFFFFFFF9);
    @(negedge clk);
    chk("R10 pulse ends", {31'd0, res_valid}, 32'd0);
    chk("R10 result held", res_int, 32'hFFFFFFF9);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule